// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Monitor

This block sits passively beside a four-bank SDRAM command bus. On every rising clock edge it decodes the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-select and A10 lines. From these it keeps a small state machine for each bank. A bank can be idle, opening, row open, reading, writing, recovering from a write, closing or refreshing. Each bank also has down-counters that enforce the minimum cycle spacings between commands.

When a command breaks a rule, the monitor raises a one-cycle error pulse together with a 4-bit reason code and the number of the offending bank. An illegal command is dropped, so it has no effect on the tracked bank state. All delays are parameters given in clock cycles, and each must be at least 2. A controller team instantiates the monitor next to its command path and watches the error pulse during simulation or on-chip debug.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command sent in a cycle is judged, and the verdict is registered on the next rising edge. err_pulse is high for that one cycle with err_code nonzero. When no error is reported, err_code is 0. The command encoding on {cs_n,ras_n,cas_n,we_n} is: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode set 0000, burst stop 0110, no-op 0111. When cs_n is high the bus is deselected and nothing is judged.
- R2: An activate to a bank that is not idle is reported. The code is 9 if that bank is still closing (tRP), 10 if it is refreshing (tRC), and 1 for any other non-idle state.
- R3: A read or write to a bank that is idle, closing or refreshing reports code 2. A read or write issued fewer than T_RCD cycles after that bank's activate reports code 3.
- R4: A precharge that reaches a bank fewer than T_RAS cycles after that bank's activate reports code 4. With A10 high the precharge reaches and closes every bank. With A10 low it reaches only the bank on ba.
- R5: An activate issued fewer than T_RRD cycles after the last accepted activate, to any bank, reports code 5.
- R6: A read or write with A10 high sets auto-close on that bank. For a read issued in cycle c, the bank stays locked until cycle c+BURST. For a write, it stays locked until cycle c+BURST+T_DPL. While locked, any read, write, activate or precharge reaching that bank reports code 6. The bank then closes for T_RP cycles.
- R7: A mode-set or refresh while any bank is not idle reports code 7. An accepted refresh holds every bank busy for T_RC cycles.
- R8: CKE falling with any command other than refresh is a power-down entry. If any bank is neither idle nor row-open, it reports code 8. A refresh with CKE falling enters self-refresh. Any command in a cycle whose previous cycle had CKE low is ignored and reports nothing.
- R9: A command that reports an error leaves every bank's state unchanged.
- R10: err_bank gives the offending bank. When a command reaches several banks, err_bank is the lowest-numbered bank that breaks a rule.
- R11: Without auto-close, a bank returns to row-open BURST cycles after a read. After a write it returns to row-open BURST+T_DPL cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | All-bank precharge / auto-close flag |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Violation reason code |
| err_bank | output | BA_W | Bank that broke the rule |

## Verification
The main coincidence is a bank timer expiring in the same cycle that a new command for that bank arrives. Examples are the last cycle of a burst, of write recovery, of closing or of refresh. Each timing rule is swept by placing the second command at every offset from 1 to one past the limit, so the expiry cycle itself is hit. The expected code at each offset is derived arithmetically from the parameters. A second coincidence is a CKE fall during an active burst, which is swept the same way against the burst and recovery lengths.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE, BK_OPENING, BK_ROW, BK_READ, BK_WRITE, BK_WREC, BK_CLOSING, BK_REFRESH
  } bank_e;

  localparam logic [3:0] ERR_NONE     = 4'd0;
  localparam logic [3:0] ERR_OPEN     = 4'd1;
  localparam logic [3:0] ERR_CLOSED   = 4'd2;
  localparam logic [3:0] ERR_RCD      = 4'd3;
  localparam logic [3:0] ERR_RAS      = 4'd4;
  localparam logic [3:0] ERR_RRD      = 4'd5;
  localparam logic [3:0] ERR_LOCKED   = 4'd6;
  localparam logic [3:0] ERR_NOT_IDLE = 4'd7;
  localparam logic [3:0] ERR_PDOWN    = 4'd8;
  localparam logic [3:0] ERR_RP       = 4'd9;
  localparam logic [3:0] ERR_RFSH     = 4'd10;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int CW    = 4,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_DPL = 2,
  parameter int T_RC  = 8,
  parameter int BURST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  cmd_e       cmd,
  input  logic       hit,
  input  logic       a10,
  input  logic       commit,
  output logic [3:0] viol,
  output logic       idle,
  output logic       pd_ok
);

  bank_e         st, st_n;
  logic [CW-1:0] cnt, cnt_n, ras, ras_n;
  logic          ap, ap_n;
  logic          locked;

  assign locked = ap && (st == BK_READ || st == BK_WRITE || st == BK_WREC);
  assign idle   = (st == BK_IDLE);
  assign pd_ok  = (st == BK_IDLE) || (st == BK_ROW);

  always_comb begin
    viol = ERR_NONE;
    if (hit) begin
      case (cmd)
        CMD_ACT: begin
          if (locked)                 viol = ERR_LOCKED;
          else if (st == BK_CLOSING)  viol = ERR_RP;
          else if (st == BK_REFRESH)  viol = ERR_RFSH;
          else if (st != BK_IDLE)     viol = ERR_OPEN;
        end
        CMD_RD, CMD_WR: begin
          if (locked) viol = ERR_LOCKED;
          else if (st == BK_IDLE || st == BK_CLOSING || st == BK_REFRESH) viol = ERR_CLOSED;
          else if (st == BK_OPENING) viol = ERR_RCD;
        end
        CMD_PRE: begin
          if (locked)                viol = ERR_LOCKED;
          else if (st == BK_REFRESH) viol = ERR_RFSH;
          else if (st != BK_IDLE && st != BK_CLOSING && ras != '0) viol = ERR_RAS;
        end
        CMD_REF, CMD_MRS: if (st != BK_IDLE) viol = ERR_NOT_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    st_n  = st;
    ap_n  = ap;
    cnt_n = (cnt != '0) ? cnt - CW'(1) : cnt;
    ras_n = (ras != '0) ? ras - CW'(1) : ras;
    if (cnt == CW'(1)) begin
      case (st)
        BK_OPENING: st_n = BK_ROW;
        BK_READ, BK_WREC: begin
          if (ap) begin st_n = BK_CLOSING; cnt_n = CW'(T_RP); end
          else    st_n = BK_ROW;
          ap_n = 1'b0;
        end
        BK_WRITE: begin st_n = BK_WREC; cnt_n = CW'(T_DPL); end
        BK_CLOSING, BK_REFRESH: st_n = BK_IDLE;
        default: ;
      endcase
    end
    if (commit && hit) begin
      case (cmd)
        CMD_ACT: begin
          st_n = BK_OPENING; cnt_n = CW'(T_RCD - 1); ras_n = CW'(T_RAS - 1); ap_n = 1'b0;
        end
        CMD_RD: begin st_n = BK_READ;  cnt_n = CW'(BURST - 1); ap_n = a10; end
        CMD_WR: begin st_n = BK_WRITE; cnt_n = CW'(BURST - 1); ap_n = a10; end
        CMD_PRE: if (st != BK_IDLE && st != BK_CLOSING) begin
          st_n = BK_CLOSING; cnt_n = CW'(T_RP - 1); ap_n = 1'b0;
        end
        CMD_BST: if (!ap) begin
          if (st == BK_READ)       begin st_n = BK_ROW;  cnt_n = '0; end
          else if (st == BK_WRITE) begin st_n = BK_WREC; cnt_n = CW'(T_DPL); end
        end
        CMD_REF: begin st_n = BK_REFRESH; cnt_n = CW'(T_RC - 1); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      cnt <= '0;
      ras <= '0;
      ap  <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      ras <= ras_n;
      ap  <= ap_n;
    end
  end

endmodule

// File: rtl/sdram_mon_pick.sv
module sdram_mon_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0][3:0] codes,
  output logic [3:0]        code,
  output logic [IW-1:0]     idx
);

  always_comb begin
    code = 4'd0;
    idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (codes[i] != 4'd0) begin
        code = codes[i];
        idx  = IW'(i);
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_RRD = 2,
  parameter int T_DPL = 2,
  parameter int T_RC  = 8,
  parameter int BURST = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            err_pulse,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);

  localparam int N_BANK = 1 << BA_W;
  localparam int MAXT   = max_int(max_int(max_int(T_RCD, T_RAS), max_int(T_RP, T_RRD)),
                                  max_int(max_int(T_DPL, T_RC), BURST + T_DPL));
  localparam int CW     = $clog2(MAXT + 1);

  cmd_e                   cmd_raw, cmd_eff;
  logic                   cke_q, pd_entry, commit;
  logic [CW-1:0]          rrd_cnt;
  logic [N_BANK-1:0]      hit, idle_v, pd_ok_v;
  logic [N_BANK-1:0][3:0] bank_viol, pd_viol;
  logic [3:0]             bcode, pcode, fcode;
  logic [BA_W-1:0]        bidx, pidx, fbank;

  assign cmd_raw  = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign cmd_eff  = cke_q ? cmd_raw : CMD_NOP;
  assign pd_entry = cke_q && !cke && (cmd_raw != CMD_REF);

  for (genvar i = 0; i < N_BANK; i++) begin : g_bank
    assign hit[i] = ((cmd_eff == CMD_ACT || cmd_eff == CMD_RD || cmd_eff == CMD_WR) &&
                     ba == BA_W'(i)) ||
                    (cmd_eff == CMD_PRE && (a10 || ba == BA_W'(i))) ||
                    cmd_eff == CMD_REF || cmd_eff == CMD_MRS || cmd_eff == CMD_BST;
    assign pd_viol[i] = (pd_entry && !pd_ok_v[i]) ? ERR_PDOWN : ERR_NONE;

    sdram_mon_bank #(
      .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_DPL(T_DPL), .T_RC(T_RC), .BURST(BURST)
    ) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd_eff), .hit(hit[i]), .a10(a10),
      .commit(commit), .viol(bank_viol[i]), .idle(idle_v[i]), .pd_ok(pd_ok_v[i])
    );
  end

  sdram_mon_pick #(.N(N_BANK), .IW(BA_W)) u_pick_cmd (
    .codes(bank_viol), .code(bcode), .idx(bidx)
  );
  sdram_mon_pick #(.N(N_BANK), .IW(BA_W)) u_pick_pd (
    .codes(pd_viol), .code(pcode), .idx(pidx)
  );

  always_comb begin
    fcode = ERR_NONE;
    fbank = '0;
    if (bcode != ERR_NONE) begin
      fcode = bcode; fbank = bidx;
    end else if (cmd_eff == CMD_ACT && rrd_cnt != '0) begin
      fcode = ERR_RRD; fbank = ba;
    end else if (pcode != ERR_NONE) begin
      fcode = pcode; fbank = pidx;
    end
  end

  assign commit = (fcode == ERR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q     <= 1'b1;
      rrd_cnt   <= '0;
      err_pulse <= 1'b0;
      err_code  <= ERR_NONE;
      err_bank  <= '0;
    end else begin
      cke_q     <= cke;
      if (commit && cmd_eff == CMD_ACT) rrd_cnt <= CW'(T_RRD - 1);
      else if (rrd_cnt != '0)           rrd_cnt <= rrd_cnt - CW'(1);
      err_pulse <= (fcode != ERR_NONE);
      err_code  <= fcode;
      err_bank  <= fbank;
    end
  end

endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk
  import sdram_mon_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       err_pulse,
  input logic [3:0] err_code
);

  cmd_e cmd;
  logic cke_d, prev_act, prev_ref, act_live, ref_live;

  assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign act_live = cke_d && (cmd == CMD_ACT);
  assign ref_live = cke_d && (cmd == CMD_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_d    <= 1'b1;
      prev_act <= 1'b0;
      prev_ref <= 1'b0;
    end else begin
      cke_d    <= cke;
      prev_act <= act_live;
      prev_ref <= ref_live;
    end
  end

  assert_pulse_has_code_R1: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_code != 4'd0);

  assert_quiet_code_R1: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> err_code == 4'd0);

  assert_asleep_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !cke_d |=> !err_pulse);

  assert_back_to_back_act_R5: assert property (@(posedge clk) disable iff (rst)
    (act_live && prev_act && !err_pulse) |=> err_pulse);

  assert_act_after_refresh_R7: assert property (@(posedge clk) disable iff (rst)
    (act_live && prev_ref && !err_pulse) |=> err_pulse);

endmodule

bind sdram_cmd_monitor sdram_mon_chk u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/sdram_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_test;

  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RRD = 2, T_DPL = 2, T_RC = 8, BURST = 4;
  localparam int OP_NOP = 0, OP_ACT = 1, OP_RD = 2, OP_WR = 3, OP_PRE = 4,
                 OP_REF = 5, OP_MRS = 6, OP_BST = 7;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic err_pulse;
  logic [3:0] err_code;
  logic [1:0] err_bank;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(
    .BA_W(2), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD),
    .T_DPL(T_DPL), .T_RC(T_RC), .BURST(BURST)
  ) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_pulse(err_pulse), .err_code(err_code),
    .err_bank(err_bank)
  );

  // drive a command, wait one edge; outputs then hold this command's verdict
  task automatic step(input int op, input int bank = 0, input logic av = 1'b0,
                      input logic ck = 1'b1);
    logic [3:0] enc;
    case (op)
      OP_ACT: enc = 4'b0011;
      OP_RD:  enc = 4'b0101;
      OP_WR:  enc = 4'b0100;
      OP_PRE: enc = 4'b0010;
      OP_REF: enc = 4'b0001;
      OP_MRS: enc = 4'b0000;
      OP_BST: enc = 4'b0110;
      default: enc = 4'b0111;
    endcase
    {cs_n, ras_n, cas_n, we_n} = enc;
    ba = 2'(bank); a10 = av; cke = ck;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic ck = 1'b1);
    for (int i = 0; i < n; i++) step(OP_NOP, 0, 1'b0, ck);
  endtask

  task automatic expect_v(input string tag, input int ec, input int eb);
    nchk++;
    if (err_pulse !== (ec != 0) || err_code !== 4'(ec) || (ec != 0 && err_bank !== 2'(eb))) begin
      nerr++;
      $display("FAIL %s: pulse=%0b code=%0d bank=%0d expected code=%0d bank=%0d",
               tag, err_pulse, err_code, err_bank, ec, eb);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111; cke = 1'b1; a10 = 1'b0; ba = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    expect_v("R1 reset state", 0, 0);

    // R3: tRCD sweep
    for (int k = 1; k <= T_RCD + 1; k++) begin
      do_reset(); step(OP_ACT, 0); idle(k - 1); step(OP_RD, 0);
      expect_v($sformatf("R3 read %0d after activate", k), (k < T_RCD) ? 3 : 0, 0);
    end
    // R4: tRAS sweep
    for (int k = 1; k <= T_RAS + 1; k++) begin
      do_reset(); step(OP_ACT, 1); idle(k - 1); step(OP_PRE, 1);
      expect_v($sformatf("R4 precharge %0d after activate", k), (k < T_RAS) ? 4 : 0, 1);
    end
    // R5: tRRD sweep
    for (int k = 1; k <= T_RRD + 1; k++) begin
      do_reset(); step(OP_ACT, 0); idle(k - 1); step(OP_ACT, 1);
      expect_v($sformatf("R5 second activate %0d later", k), (k < T_RRD) ? 5 : 0, 1);
    end
    // R2: tRP sweep
    for (int k = 1; k <= T_RP + 1; k++) begin
      do_reset(); step(OP_ACT, 0); idle(T_RAS - 1); step(OP_PRE, 0);
      idle(k - 1); step(OP_ACT, 0);
      expect_v($sformatf("R2 activate %0d after precharge", k), (k < T_RP) ? 9 : 0, 0);
    end
    // R7/R2: refresh busy window
    for (int k = 1; k <= T_RC + 1; k++) begin
      do_reset(); step(OP_REF); idle(k - 1); step(OP_ACT, 2);
      expect_v($sformatf("R7 activate %0d after refresh", k), (k < T_RC) ? 10 : 0, 2);
    end
    // R6: write with auto-close
    for (int k = 1; k <= BURST + T_DPL + T_RP + 1; k++) begin
      int e;
      e = (k < BURST + T_DPL) ? 6 : (k < BURST + T_DPL + T_RP) ? 9 : 0;
      do_reset(); step(OP_ACT, 1); idle(T_RCD - 1); step(OP_WR, 1, 1'b1);
      idle(k - 1); step(OP_ACT, 1);
      expect_v($sformatf("R6 activate %0d after auto-close write", k), e, 1);
    end
    // R6: read with auto-close
    for (int k = 1; k <= BURST + T_RP + 1; k++) begin
      do_reset(); step(OP_ACT, 2); idle(T_RCD - 1); step(OP_RD, 2, 1'b1);
      idle(k - 1); step(OP_RD, 2);
      expect_v($sformatf("R6 read %0d after auto-close read", k), (k < BURST) ? 6 : 2, 2);
    end
    // R11/R8: write recovery and read burst seen through power-down entry
    for (int k = 1; k <= BURST + T_DPL + 1; k++) begin
      do_reset(); step(OP_ACT, 0); idle(T_RCD - 1); step(OP_WR, 0);
      idle(k - 1); step(OP_NOP, 0, 1'b0, 1'b0);
      expect_v($sformatf("R11 power-down %0d after write", k), (k < BURST + T_DPL) ? 8 : 0, 0);
    end
    for (int k = 1; k <= BURST + 1; k++) begin
      do_reset(); step(OP_ACT, 3); idle(T_RCD - 1); step(OP_RD, 3);
      idle(k - 1); step(OP_NOP, 0, 1'b0, 1'b0);
      expect_v($sformatf("R11 power-down %0d after read", k), (k < BURST) ? 8 : 0, 3);
    end

    // R2: activate to open bank
    do_reset(); step(OP_ACT, 0); idle(T_RRD + 1); step(OP_ACT, 0);
    expect_v("R2 activate open bank", 1, 0);
    // R3: read to idle bank
    do_reset(); step(OP_RD, 3); expect_v("R3 read idle bank", 2, 3);
    // R7/R10: mode set with open bank, and when all idle
    do_reset(); step(OP_MRS); expect_v("R7 mode set all idle", 0, 0);
    step(OP_ACT, 2); idle(2); step(OP_MRS); expect_v("R7 R10 mode set with bank 2 open", 7, 2);
    // R4/R10: all-bank precharge
    do_reset(); step(OP_ACT, 0); idle(T_RRD - 1); step(OP_ACT, 3);
    idle(T_RAS - T_RRD - 1); step(OP_PRE, 0, 1'b1);
    expect_v("R4 R10 all-bank precharge too early for bank 3", 4, 3);
    idle(T_RRD - 1); step(OP_PRE, 0, 1'b1); expect_v("R4 all-bank precharge", 0, 0);
    idle(T_RP - 1); step(OP_ACT, 3); expect_v("R4 bank 3 closed", 0, 3);
    idle(T_RRD - 1); step(OP_ACT, 0); expect_v("R4 bank 0 closed", 0, 0);
    // R4: single-bank precharge
    do_reset(); step(OP_ACT, 0); idle(T_RRD - 1); step(OP_ACT, 1); idle(T_RAS);
    step(OP_PRE, 0); expect_v("R4 single precharge", 0, 0);
    step(OP_RD, 1); expect_v("R4 other bank still open", 0, 1);
    step(OP_RD, 0); expect_v("R4 target bank closed", 2, 0);
    // R9: illegal activate leaves bank closed
    do_reset(); step(OP_ACT, 0); step(OP_ACT, 1); expect_v("R9 early activate", 5, 1);
    idle(T_RCD + 2); step(OP_RD, 1); expect_v("R9 rejected activate had no effect", 2, 1);
    // R8: commands ignored while clock enable low
    do_reset(); step(OP_ACT, 0); idle(T_RAS);
    step(OP_NOP, 0, 1'b0, 1'b0); expect_v("R8 power-down from row open", 0, 0);
    step(OP_ACT, 1, 1'b0, 1'b0); expect_v("R8 ignored activate", 0, 0);
    step(OP_RD, 2, 1'b0, 1'b0); expect_v("R8 ignored read", 0, 0);
    step(OP_NOP, 0, 1'b0, 1'b1); expect_v("R8 wake cycle", 0, 0);
    step(OP_RD, 1); expect_v("R8 ignored activate left bank 1 idle", 2, 1);
    step(OP_RD, 0); expect_v("R8 bank 0 still open", 0, 0);
    // R8: self-refresh
    do_reset(); step(OP_REF, 0, 1'b0, 1'b0); expect_v("R8 self-refresh entry", 0, 0);
    idle(T_RC, 1'b0); step(OP_NOP); step(OP_ACT, 0); expect_v("R8 activate after self-refresh", 0, 0);
    do_reset(); step(OP_ACT, 0); idle(T_RAS);
    step(OP_REF, 0, 1'b0, 1'b0); expect_v("R8 R7 self-refresh with open bank", 7, 0);
    // R1: deselected bus
    do_reset(); cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b0; @(negedge clk);
    expect_v("R1 deselect ignored", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule